// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns processor virtual addresses into 36-bit physical addresses. The upper four bits of a physical address name a bus slot, the next twenty bits name a page frame, and the low twelve bits pass through from the virtual address unchanged. Recent page descriptors are kept in a small direct-mapped translation buffer. Each entry is tagged with the privilege level that loaded it.

When a lookup misses, the block holds the processor's cycle and makes exactly two reads from main memory. The first read fetches a pointer-table word. Its address is formed from a root frame, chosen by the supervisor bit, and from virtual bits 30:22. The second read fetches a page descriptor. Its address is formed from the frame held in that pointer word and from virtual bits 21:12. A resident descriptor is written into the buffer, and on the next cycle the stalled request completes from the buffer. A word marked not resident ends the walk with a fault, and nothing is written into the buffer. An invalidate input clears every valid bit in one cycle.

Top module: `pt_walker`

## Requirements
- R1: While `req_valid_i` is high and the buffer slot addressed by virtual bits 12 and up holds a valid entry whose tag (supervisor bit plus the remaining upper virtual bits) matches, `done_o` is high in that same cycle. In that cycle `pa_o` equals {stored 24-bit frame, va[11:0]} and `mem_req_o` stays low.
- R2: On a miss, `done_o` stays low. In the next cycle `mem_req_o` rises and the pointer-word read begins.
- R3: The pointer-word read address is {root, 1'b0, va[30:22], 2'b00}. The root is `sup_root_i` when `req_sup_i` is 1 and `usr_root_i` when it is 0.
- R4: After a resident pointer word arrives, the descriptor read address is {pointer[31:8], va[21:12], 2'b00}.
- R5: While `mem_req_o` is high and `mem_rvalid_i` is low, `mem_req_o` stays high and `mem_addr_o` stays stable in the next cycle.
- R6: `done_o` stays low during a walk. In the cycle after a resident descriptor is returned, `done_o` is high and `pa_o` = {descriptor[31:8], va[11:0]}.
- R7: A pointer word or descriptor with bit 0 clear (not resident) makes `done_o` and `fault_o` high together for exactly one cycle. The buffer is not loaded, so the same request misses again.
- R8: The buffer is direct mapped. A fill replaces whatever entry sits at its index, so the displaced address misses on its next access.
- R9: A one-cycle pulse on `inval_i` clears every valid bit, and every following access misses.
- R10: After reset, `done_o`, `fault_o` and `mem_req_o` are low and every buffer entry is invalid.
- R11: An entry loaded at one privilege level does not hit for the same virtual address at the other level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request, held until `done_o` |
| req_va_i | input | 31 | Virtual address |
| req_sup_i | input | 1 | Supervisor bit of the request |
| sup_root_i | input | 24 | Supervisor root frame |
| usr_root_i | input | 24 | User root frame |
| inval_i | input | 1 | Invalidate all buffer entries |
| done_o | output | 1 | Request complete (hit or fault) |
| fault_o | output | 1 | Page-not-resident fault, valid with `done_o` |
| pa_o | output | 36 | Physical address {slot, page, offset} |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | 36 | Memory read byte address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data word |

## Verification
The bench builds the block with `TLB_ENTRIES` = 4, which leaves two index bits. Addresses that differ only above bit 13 therefore collide, so the bench can reach eviction and same-slot replacement with a handful of addresses. It can also show a supervisor fill displacing a user entry at the same virtual address. The two root frames are set to distinct values, so each walk shows which root was chosen. The bench's memory model builds every returned word from its own address, which exposes any error in how an index or a frame is placed in the read address.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int VA_W    = 31;
  localparam int OFS_W   = 12;
  localparam int FRAME_W = 24;
  localparam int DESC_W  = 32;
  localparam int PA_W    = FRAME_W + OFS_W;
  localparam int DIR_W   = 9;
  localparam int TBL_W   = 10;
  localparam int RES_BIT = 0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_PTR,
    ST_RD_DESC,
    ST_FAULT
  } walk_st_e;
endpackage

// File: rtl/pt_walker_tlb.sv
module pt_walker_tlb
  import pt_walker_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [VA_W-1:0]    lookup_va_i,
  input  logic               lookup_sup_i,
  output logic               hit_o,
  output logic [FRAME_W-1:0] frame_o,
  input  logic               fill_i,
  input  logic [VA_W-1:0]    fill_va_i,
  input  logic               fill_sup_i,
  input  logic [FRAME_W-1:0] fill_frame_i,
  input  logic               inval_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = 1 + VA_W - OFS_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];

  logic [IDX_W-1:0] ridx, widx;
  logic [TAG_W-1:0] rtag, wtag;

  assign ridx = lookup_va_i[OFS_W +: IDX_W];
  assign rtag = {lookup_sup_i, lookup_va_i[VA_W-1:OFS_W+IDX_W]};
  assign widx = fill_va_i[OFS_W +: IDX_W];
  assign wtag = {fill_sup_i, fill_va_i[VA_W-1:OFS_W+IDX_W]};

  assign hit_o   = valid_q[ridx] && (tag_q[ridx] == rtag);
  assign frame_o = frame_q[ridx];

  // invalidate wins over a same-cycle fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (inval_i) valid_q <= '0;
    else if (fill_i)  valid_q[widx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[widx]   <= wtag;
      frame_q[widx] <= fill_frame_i;
    end
  end

  assert_inval_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (valid_q == '0));
endmodule

// File: rtl/pt_walker_seq.sv
module pt_walker_seq
  import pt_walker_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic               req_sup_i,
  input  logic [FRAME_W-1:0] sup_root_i,
  input  logic [FRAME_W-1:0] usr_root_i,
  input  logic               hit_i,
  output logic               done_o,
  output logic               fault_o,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [DESC_W-1:0]  mem_rdata_i,
  output logic               fill_o,
  output logic [VA_W-1:0]    fill_va_o,
  output logic               fill_sup_o,
  output logic [FRAME_W-1:0] fill_frame_o
);
  walk_st_e           st_q, st_d;
  logic [VA_W-1:0]    va_q;
  logic               sup_q;
  logic [FRAME_W-1:0] ptr_frame_q;
  logic               resident;

  assign resident = mem_rdata_i[RES_BIT];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (req_valid_i && !hit_i) st_d = ST_RD_PTR;
      ST_RD_PTR:  if (mem_rvalid_i) st_d = resident ? ST_RD_DESC : ST_FAULT;
      ST_RD_DESC: if (mem_rvalid_i) st_d = resident ? ST_IDLE : ST_FAULT;
      ST_FAULT:   st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      va_q        <= '0;
      sup_q       <= 1'b0;
      ptr_frame_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid_i && !hit_i) begin
        va_q  <= req_va_i;
        sup_q <= req_sup_i;
      end
      if (st_q == ST_RD_PTR && mem_rvalid_i)
        ptr_frame_q <= mem_rdata_i[DESC_W-1 -: FRAME_W];
    end
  end

  always_comb begin
    mem_addr_o = '0;
    if (st_q == ST_RD_PTR)
      mem_addr_o = {(sup_q ? sup_root_i : usr_root_i), 1'b0,
                    va_q[OFS_W+TBL_W +: DIR_W], 2'b00};
    else if (st_q == ST_RD_DESC)
      mem_addr_o = {ptr_frame_q, va_q[OFS_W +: TBL_W], 2'b00};
  end

  assign mem_req_o    = (st_q == ST_RD_PTR) || (st_q == ST_RD_DESC);
  assign fault_o      = (st_q == ST_FAULT);
  assign done_o       = (st_q == ST_FAULT) || (st_q == ST_IDLE && req_valid_i && hit_i);
  assign fill_o       = (st_q == ST_RD_DESC) && mem_rvalid_i && resident;
  assign fill_va_o    = va_q;
  assign fill_sup_o   = sup_q;
  assign fill_frame_o = mem_rdata_i[DESC_W-1 -: FRAME_W];

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_fault_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);
  assert_fault_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  assert_no_done_in_walk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int TLB_ENTRIES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic               req_sup_i,
  input  logic [FRAME_W-1:0] sup_root_i,
  input  logic [FRAME_W-1:0] usr_root_i,
  input  logic               inval_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [PA_W-1:0]    pa_o,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [DESC_W-1:0]  mem_rdata_i
);
  logic               hit;
  logic [FRAME_W-1:0] frame;
  logic               fill;
  logic [VA_W-1:0]    fill_va;
  logic               fill_sup;
  logic [FRAME_W-1:0] fill_frame;

  pt_walker_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lookup_va_i  (req_va_i),
    .lookup_sup_i (req_sup_i),
    .hit_o        (hit),
    .frame_o      (frame),
    .fill_i       (fill),
    .fill_va_i    (fill_va),
    .fill_sup_i   (fill_sup),
    .fill_frame_i (fill_frame),
    .inval_i      (inval_i)
  );

  pt_walker_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_va_i     (req_va_i),
    .req_sup_i    (req_sup_i),
    .sup_root_i   (sup_root_i),
    .usr_root_i   (usr_root_i),
    .hit_i        (hit),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .fill_o       (fill),
    .fill_va_o    (fill_va),
    .fill_sup_o   (fill_sup),
    .fill_frame_o (fill_frame)
  );

  // slot+page from buffer, byte offset straight from the request
  assign pa_o = {frame, req_va_i[OFS_W-1:0]};

  assert_hit_quiet_mem_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> !mem_req_o);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int CLK_NS = 10;
  localparam logic [23:0] SUP_ROOT = 24'hA12345;
  localparam logic [23:0] USR_ROOT = 24'h3BCDE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [30:0] req_va = '0;
  logic        req_sup = 1'b0;
  logic        inval = 1'b0;
  logic        done, fault, mem_req, mem_rvalid = 1'b0;
  logic [35:0] pa, mem_addr;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  // reference buffer state
  bit          m_valid [4];
  logic [17:0] m_tag   [4];
  logic [23:0] m_frame [4];

  always #(CLK_NS/2) clk = ~clk;

  pt_walker #(.TLB_ENTRIES(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_va_i(req_va),
    .req_sup_i(req_sup), .sup_root_i(SUP_ROOT), .usr_root_i(USR_ROOT),
    .inval_i(inval), .done_o(done), .fault_o(fault), .pa_o(pa),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [35:0] addr, input bit res);
    return {addr[31:8] ^ 24'h3C5A96, 7'b0, res};
  endfunction

  task automatic access(input logic [30:0] va, input bit sup, input bit nr_ptr, input bit nr_desc);
    int idx = int'(va[13:12]);
    logic [17:0] tag = {sup, va[30:14]};
    bit hit_exp = m_valid[idx] && (m_tag[idx] == tag);
    logic [35:0] paddr, daddr;
    logic [31:0] pd, dd;
    @(negedge clk); req_valid = 1'b1; req_va = va; req_sup = sup; #2;
    if (hit_exp) begin
      chk(done == 1'b1, "R1 hit done", done, 1);
      chk(pa == {m_frame[idx], va[11:0]}, "R1 hit pa", pa, {m_frame[idx], va[11:0]});
      chk(mem_req == 1'b0, "R1 no mem on hit", mem_req, 0);
    end else begin
      chk(done == 1'b0, "R2 miss no done", done, 0);
      paddr = {sup ? SUP_ROOT : USR_ROOT, 1'b0, va[30:22], 2'b00};
      @(negedge clk); #2;
      chk(mem_req == 1'b1, "R2 walk starts", mem_req, 1);
      chk(mem_addr == paddr, "R3 pointer addr/root", mem_addr, paddr);
      pd = mem_word(paddr, !nr_ptr);
      @(negedge clk); mem_rvalid = 1'b1; mem_rdata = pd; #2;
      chk(mem_req == 1'b1 && mem_addr == paddr, "R5 hold pointer read", mem_addr, paddr);
      chk(done == 1'b0, "R6 no done in walk", done, 0);
      @(negedge clk); mem_rvalid = 1'b0; #2;
      if (nr_ptr) begin
        chk(done && fault, "R7 pointer fault", {done, fault}, 2'b11);
      end else begin
        daddr = {pd[31:8], va[21:12], 2'b00};
        chk(mem_req == 1'b1 && mem_addr == daddr, "R4 descriptor addr", mem_addr, daddr);
        chk(done == 1'b0, "R6 no done in walk", done, 0);
        dd = mem_word(daddr, !nr_desc);
        @(negedge clk); mem_rvalid = 1'b1; mem_rdata = dd; #2;
        chk(mem_req == 1'b1 && mem_addr == daddr, "R5 hold descriptor read", mem_addr, daddr);
        @(negedge clk); mem_rvalid = 1'b0; #2;
        if (nr_desc) begin
          chk(done && fault, "R7 descriptor fault", {done, fault}, 2'b11);
        end else begin
          chk(done && !fault, "R6 resume done", {done, fault}, 2'b10);
          chk(pa == {dd[31:8], va[11:0]}, "R6 resume pa", pa, {dd[31:8], va[11:0]});
          m_valid[idx] = 1'b1; m_tag[idx] = tag; m_frame[idx] = dd[31:8];
        end
      end
    end
    @(negedge clk); req_valid = 1'b0; #2;
    chk(!done && !fault && !mem_req, "R7 idle after done", {done, fault, mem_req}, 0);
  endtask

  task automatic do_inval();
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
    for (int i = 0; i < 4; i++) m_valid[i] = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_valid[i] = 1'b0;
    #3;
    chk(!done && !fault && !mem_req, "R10 reset outputs", {done, fault, mem_req}, 0);
    @(negedge clk); rst_n = 1'b1;
    // R10: first accesses all miss (buffer empty)
    access(31'h0123_4567, 1'b0, 0, 0);
    access(31'h0123_4567, 1'b0, 0, 0);           // R1 hit
    access(31'h0123_4ABC, 1'b0, 0, 0);           // R1 same page, other offset
    access(31'h0123_4567, 1'b1, 0, 0);           // R11 + R3 supervisor miss
    access(31'h0123_4567, 1'b0, 0, 0);           // R8 user displaced
    access(31'h7FC0_1000, 1'b1, 0, 0);           // idx 1
    access(31'h7FC0_1FFF, 1'b1, 0, 0);           // hit idx 1
    access(31'h2000_5010, 1'b0, 0, 0);           // idx 1 conflict, R8
    access(31'h7FC0_1000, 1'b1, 0, 0);           // R8 misses again
    access(31'h1555_2000, 1'b0, 0, 1);           // R7 descriptor fault
    access(31'h1555_2000, 1'b0, 0, 0);           // R7 no fill: misses again
    access(31'h1555_2000, 1'b0, 0, 0);           // now hits
    access(31'h0AAA_3000, 1'b1, 1, 0);           // R7 pointer fault
    access(31'h0AAA_3000, 1'b1, 0, 0);
    access(31'h0AAA_3000, 1'b1, 0, 0);
    do_inval();                                  // R9
    access(31'h1555_2000, 1'b0, 0, 0);           // R9 miss after invalidate
    access(31'h0AAA_3000, 1'b1, 0, 0);
    access(31'h1555_2000, 1'b0, 0, 0);
    for (int k = 0; k < 8; k++)
      access({k[2:0], 28'h0F3_0000} | (31'(k) << 12), k[0], 0, 0);
    for (int k = 0; k < 8; k++)
      access({k[2:0], 28'h0F3_0000} | (31'(k) << 12), k[0], 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule